// File: doc/BRIEF.md
# Directory Coherence State Controller

This block is the home directory for one slice of the address space in a multi-core cache system. For every cache line it tracks, it keeps three bit vectors with one bit per core: valid, dirty and shared. Together these encode each core's MOESI state. A core sends one request at a time: an upgrade (invalidate), a memory writeback, a read for load or a read for store.

For each request the controller computes the new per-core vectors in a single cycle and writes them back. In the following cycle it issues a command pulse that lists the cores to invalidate, the cores that must copy their dirty data back, and the memory channel to use, either for a fetch or for a write.

It then holds off new requests until every core and memory acknowledgement it asked for has arrived. A registered lookup port returns the stored vectors of any line, so software-free checking of the directory contents is possible from the ports.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset every line reads back all-invalid on the lookup port, `req_ready` is 1 and `cmd_valid` is 0.
- R2: Per-core encoding on the lookup port, as {valid,dirty,shared}, is:
  - 0xx: invalid
  - 100: exclusive clean
  - 101: shared clean
  - 110: modified
  - 111: owned

  The lookup outputs appear one cycle after `look_line` is applied.
- R3: Upgrade (`req_kind`=0): every other valid core is invalidated, and a dirty other core also gets a copyback. The requester becomes modified. No memory command is issued.
- R4: Writeback (`req_kind`=1): the requester and every other holder become invalid, and other holders get an invalidate. A dirty other holder also gets a copyback. A memory write (`mem_write`=1) goes to channel `req_line % NMEM` only when the requester was dirty.
- R5: Read for load (`req_kind`=2):
  - The home core (valid and dirty) gets a copyback without an invalidate and becomes owned.
  - Shared cores are unchanged, and exclusive cores become shared.
  - The requester becomes shared, or exclusive if no other core holds the line.
  - If the requester is itself the home core, nothing changes and no command is sent.
- R6: Read for store (`req_kind`=3): the home core gets copyback plus invalidate, every other holder is invalidated, and the requester becomes modified.
- R7: A read for load or a read for store with no home core anywhere issues a fetch (`mem_write`=0) on channel `req_line % NMEM`. At most one `mem_req` bit is ever set.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until every expected `core_ack` and `mem_ack` bit has been seen, in any cycles and in any order. It returns to 1 the cycle after the last one.
- R9: At most one core per line is ever home.
- R10: Commands are a one-cycle `cmd_valid` pulse in the cycle after acceptance. They never target the requester or a core that was invalid.
- R11: A request changes only the line it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_kind | input | 2 | 0 upgrade, 1 writeback, 2 read for load, 3 read for store |
| req_core | input | $clog2(NCORES) | Requesting core |
| req_line | input | $clog2(NLINES) | Line index |
| cmd_valid | output | 1 | Command pulse |
| cmd_inval | output | NCORES | Cores to invalidate |
| cmd_copyback | output | NCORES | Cores to copy dirty data back |
| mem_req | output | NMEM | Memory channel command, one-hot |
| mem_write | output | 1 | 1 write, 0 fetch |
| core_ack | input | NCORES | Per-core acknowledgements |
| mem_ack | input | NMEM | Per-channel acknowledgements |
| look_line | input | $clog2(NLINES) | Line to inspect |
| look_v | output | NCORES | Valid vector of inspected line |
| look_d | output | NCORES | Dirty vector of inspected line |
| look_s | output | NCORES | Shared vector of inspected line |

## Verification
The hardest state to reach is an owned line with extra shared readers, followed by an upgrade from one of those readers. That one request must produce both a copyback and an invalidate for the owner, and a plain invalidate for the other sharer.

The stimulus builds it step by step on one line: an exclusive fill, a second reader, a store, then two loads that create the owner and its sharers, and finally the upgrade. The ready hold-off is exercised by withholding acknowledgements for several cycles and then returning them in two separate groups.

// File: rtl/dircoh_pkg.sv
package dircoh_pkg;
  typedef enum logic [1:0] {
    K_UPGRADE = 2'd0,
    K_WRBACK  = 2'd1,
    K_RDLOAD  = 2'd2,
    K_RDSTORE = 2'd3
  } req_kind_e;
endpackage

// File: rtl/dircoh_store.sv
module dircoh_store #(
  parameter int NCORES = 4,
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LW-1:0]     wr_line,
  input  logic [NCORES-1:0] wr_v,
  input  logic [NCORES-1:0] wr_d,
  input  logic [NCORES-1:0] wr_s,
  input  logic [LW-1:0]     rd_line,
  output logic [NCORES-1:0] rd_v,
  output logic [NCORES-1:0] rd_d,
  output logic [NCORES-1:0] rd_s,
  input  logic [LW-1:0]     lk_line,
  output logic [NCORES-1:0] lk_v,
  output logic [NCORES-1:0] lk_d,
  output logic [NCORES-1:0] lk_s
);
  logic [NCORES-1:0] vmem [NLINES];
  logic [NCORES-1:0] dmem [NLINES];
  logic [NCORES-1:0] smem [NLINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINES; i++) begin
        vmem[i] <= '0;
        dmem[i] <= '0;
        smem[i] <= '0;
      end
    end else if (wr_en) begin
      vmem[wr_line] <= wr_v;
      dmem[wr_line] <= wr_d;
      smem[wr_line] <= wr_s;
    end
  end

  assign rd_v = vmem[rd_line];
  assign rd_d = dmem[rd_line];
  assign rd_s = smem[rd_line];

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_v <= '0;
      lk_d <= '0;
      lk_s <= '0;
    end else begin
      lk_v <= vmem[lk_line];
      lk_d <= dmem[lk_line];
      lk_s <= smem[lk_line];
    end
  end

  assert_single_home_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_v & lk_d));
endmodule

// File: rtl/dircoh_next.sv
module dircoh_next
  import dircoh_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  req_kind_e         kind,
  input  logic [NCORES-1:0] req_mask,
  input  logic [NCORES-1:0] cur_v,
  input  logic [NCORES-1:0] cur_d,
  input  logic [NCORES-1:0] cur_s,
  output logic [NCORES-1:0] nxt_v,
  output logic [NCORES-1:0] nxt_d,
  output logic [NCORES-1:0] nxt_s,
  output logic [NCORES-1:0] inval,
  output logic [NCORES-1:0] copyback,
  output logic              fetch,
  output logic              mwrite
);
  logic [NCORES-1:0] home, home_oth, oth_valid;

  always_comb begin
    home      = cur_v & cur_d;
    home_oth  = home & ~req_mask;
    oth_valid = cur_v & ~req_mask;
    nxt_v     = cur_v;
    nxt_d     = cur_d;
    nxt_s     = cur_s;
    inval     = '0;
    copyback  = '0;
    fetch     = 1'b0;
    mwrite    = 1'b0;
    case (kind)
      K_UPGRADE: begin
        inval    = oth_valid;
        copyback = home_oth;
        nxt_v    = req_mask;
        nxt_d    = req_mask;
        nxt_s    = '0;
      end
      K_WRBACK: begin
        inval    = oth_valid;
        copyback = home_oth;
        nxt_v    = '0;
        nxt_d    = '0;
        nxt_s    = '0;
        mwrite   = |(home & req_mask);
      end
      K_RDLOAD: begin
        if (!(|(home & req_mask))) begin
          copyback = home_oth;
          fetch    = ~|home;
          nxt_v    = cur_v | req_mask;
          nxt_s    = cur_s | oth_valid | ((|oth_valid) ? req_mask : '0);
        end
      end
      default: begin
        inval    = oth_valid;
        copyback = home_oth;
        nxt_v    = req_mask;
        nxt_d    = req_mask;
        nxt_s    = '0;
        fetch    = ~|home;
      end
    endcase
  end
endmodule

// File: rtl/dircoh_acks.sv
module dircoh_acks #(
  parameter int NCORES = 4,
  parameter int NMEM   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NCORES-1:0] exp_core,
  input  logic [NMEM-1:0]   exp_mem,
  input  logic [NCORES-1:0] core_ack,
  input  logic [NMEM-1:0]   mem_ack,
  output logic              busy
);
  logic [NCORES-1:0] pend_core;
  logic [NMEM-1:0]   pend_mem;
  logic [NCORES-1:0] left_core;
  logic [NMEM-1:0]   left_mem;

  assign left_core = pend_core & ~core_ack;
  assign left_mem  = pend_mem & ~mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pend_core <= '0;
      pend_mem  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        pend_core <= exp_core;
        pend_mem  <= exp_mem;
      end
    end else begin
      pend_core <= left_core;
      pend_mem  <= left_mem;
      if (left_core == '0 && left_mem == '0) busy <= 1'b0;
    end
  end

  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && (left_core != '0 || left_mem != '0)) |=> busy);
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
  import dircoh_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int NLINES = 8,
  parameter int NMEM   = 2,
  localparam int CW  = $clog2(NCORES),
  localparam int LW  = $clog2(NLINES),
  localparam int MCW = $clog2(NMEM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [CW-1:0]     req_core,
  input  logic [LW-1:0]     req_line,
  output logic              cmd_valid,
  output logic [NCORES-1:0] cmd_inval,
  output logic [NCORES-1:0] cmd_copyback,
  output logic [NMEM-1:0]   mem_req,
  output logic              mem_write,
  input  logic [NCORES-1:0] core_ack,
  input  logic [NMEM-1:0]   mem_ack,
  input  logic [LW-1:0]     look_line,
  output logic [NCORES-1:0] look_v,
  output logic [NCORES-1:0] look_d,
  output logic [NCORES-1:0] look_s
);
  logic              busy, accept;
  logic [NCORES-1:0] req_mask;
  logic [NCORES-1:0] cur_v, cur_d, cur_s;
  logic [NCORES-1:0] nxt_v, nxt_d, nxt_s;
  logic [NCORES-1:0] n_inval, n_cb;
  logic              n_fetch, n_mw;
  logic [NMEM-1:0]   mem_sel;
  logic [NCORES-1:0] mask_q, cur_v_q;
  req_kind_e         kind_q;

  assign req_ready = ~busy;
  assign accept    = req_valid & ~busy;
  assign req_mask  = NCORES'(1) << req_core;

  dircoh_store #(.NCORES(NCORES), .NLINES(NLINES)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(accept), .wr_line(req_line),
    .wr_v(nxt_v), .wr_d(nxt_d), .wr_s(nxt_s),
    .rd_line(req_line), .rd_v(cur_v), .rd_d(cur_d), .rd_s(cur_s),
    .lk_line(look_line), .lk_v(look_v), .lk_d(look_d), .lk_s(look_s)
  );

  dircoh_next #(.NCORES(NCORES)) u_next (
    .kind(req_kind_e'(req_kind)), .req_mask(req_mask),
    .cur_v(cur_v), .cur_d(cur_d), .cur_s(cur_s),
    .nxt_v(nxt_v), .nxt_d(nxt_d), .nxt_s(nxt_s),
    .inval(n_inval), .copyback(n_cb), .fetch(n_fetch), .mwrite(n_mw)
  );

  always_comb begin
    mem_sel = '0;
    if (n_fetch || n_mw) mem_sel[req_line[MCW-1:0]] = 1'b1;
  end

  dircoh_acks #(.NCORES(NCORES), .NMEM(NMEM)) u_acks (
    .clk(clk), .rst(rst), .start(accept),
    .exp_core(n_inval | n_cb), .exp_mem(mem_sel),
    .core_ack(core_ack), .mem_ack(mem_ack), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid    <= 1'b0;
      cmd_inval    <= '0;
      cmd_copyback <= '0;
      mem_req      <= '0;
      mem_write    <= 1'b0;
      mask_q       <= '0;
      cur_v_q      <= '0;
      kind_q       <= K_UPGRADE;
    end else begin
      cmd_valid    <= accept;
      cmd_inval    <= accept ? n_inval : '0;
      cmd_copyback <= accept ? n_cb : '0;
      mem_req      <= accept ? mem_sel : '0;
      mem_write    <= accept & n_mw;
      if (accept) begin
        mask_q  <= req_mask;
        cur_v_q <= cur_v;
        kind_q  <= req_kind_e'(req_kind);
      end
    end
  end

  assert_next_home_R9: assert property (@(posedge clk) disable iff (rst)
    accept |-> $onehot0(nxt_v & nxt_d));
  assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> cmd_valid);
  assert_cmd_single_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  assert_cmd_target_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (((cmd_inval | cmd_copyback) & (mask_q | ~cur_v_q)) == '0));
  assert_mem_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mem_req));
  assert_upgrade_no_mem_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && kind_q == K_UPGRADE) |-> (mem_req == '0));
endmodule

// File: tb/dir_coherence_ctrl_test.sv
module dir_coherence_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic       req_ready;
  logic [1:0] req_kind;
  logic [1:0] req_core;
  logic [2:0] req_line;
  logic       cmd_valid;
  logic [3:0] cmd_inval, cmd_copyback;
  logic [1:0] mem_req;
  logic       mem_write;
  logic [3:0] core_ack;
  logic [1:0] mem_ack;
  logic [2:0] look_line;
  logic [3:0] look_v, look_d, look_s;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_coherence_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_core(req_core), .req_line(req_line),
    .cmd_valid(cmd_valid), .cmd_inval(cmd_inval), .cmd_copyback(cmd_copyback),
    .mem_req(mem_req), .mem_write(mem_write), .core_ack(core_ack),
    .mem_ack(mem_ack), .look_line(look_line), .look_v(look_v),
    .look_d(look_d), .look_s(look_s)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input int c, input int l);
    @(negedge clk);
    chk("R8 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_kind  = k;
    req_core  = 2'(c);
    req_line  = 3'(l);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_cmds(input string tag, input logic [3:0] inv,
                             input logic [3:0] cb, input logic [1:0] mem,
                             input logic mw);
    chk({tag, " R10 cmd_valid"}, 32'(cmd_valid), 32'd1);
    chk({tag, " inval"}, 32'(cmd_inval), 32'(inv));
    chk({tag, " copyback"}, 32'(cmd_copyback), 32'(cb));
    chk({tag, " mem_req"}, 32'(mem_req), 32'(mem));
    if (mem != '0) chk({tag, " mem_write"}, 32'(mem_write), 32'(mw));
    chk({tag, " R8 busy"}, 32'(req_ready), 32'd0);
  endtask

  task automatic ack_all(input string tag, input logic [3:0] ca, input logic [1:0] ma);
    core_ack = ca;
    mem_ack  = ma;
    @(negedge clk);
    core_ack = '0;
    mem_ack  = '0;
    chk({tag, " R8 ready after acks"}, 32'(req_ready), 32'd1);
    chk({tag, " R10 pulse ends"}, 32'(cmd_valid), 32'd0);
  endtask

  task automatic look(input string tag, input int l, input logic [3:0] v,
                      input logic [3:0] d, input logic [3:0] s);
    look_line = 3'(l);
    @(negedge clk);
    chk({tag, " R2 valid"}, 32'(look_v), 32'(v));
    chk({tag, " R2 dirty"}, 32'(look_d), 32'(d));
    chk({tag, " R2 shared"}, 32'(look_s), 32'(s));
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 cmd_valid", 32'(cmd_valid), 32'd0);
    for (int l = 0; l < 8; l++) look("R1 empty", l, 4'h0, 4'h0, 4'h0);
  endtask

  task automatic t_first_load;
    issue(2'd2, 0, 1);
    expect_cmds("R7 fill exclusive", 4'h0, 4'h0, 2'b10, 1'b0);
    ack_all("R7 fill", 4'h0, 2'b10);
    look("R5 exclusive", 1, 4'b0001, 4'b0000, 4'b0000);
  endtask

  task automatic t_second_load;
    issue(2'd2, 1, 1);
    expect_cmds("R7 second reader", 4'h0, 4'h0, 2'b10, 1'b0);
    ack_all("R7 second", 4'h0, 2'b10);
    look("R5 both shared", 1, 4'b0011, 4'b0000, 4'b0011);
  endtask

  task automatic t_store_delayed_acks;
    issue(2'd3, 2, 1);
    expect_cmds("R6 store", 4'b0011, 4'h0, 2'b10, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 waiting for acks", 32'(req_ready), 32'd0);
    end
    core_ack = 4'b0001;
    @(negedge clk);
    core_ack = '0;
    chk("R8 partial ack", 32'(req_ready), 32'd0);
    ack_all("R8 final acks", 4'b0010, 2'b10);
    look("R6 modified", 1, 4'b0100, 4'b0100, 4'b0000);
  endtask

  task automatic t_load_from_home;
    issue(2'd2, 3, 1);
    expect_cmds("R5 load from home", 4'h0, 4'b0100, 2'b00, 1'b0);
    ack_all("R5 home", 4'b0100, 2'b00);
    look("R5 owned plus shared", 1, 4'b1100, 4'b0100, 4'b1100);
    issue(2'd2, 0, 1);
    expect_cmds("R5 second load from owner", 4'h0, 4'b0100, 2'b00, 1'b0);
    ack_all("R5 owner", 4'b0100, 2'b00);
    look("R5 sharers kept", 1, 4'b1101, 4'b0100, 4'b1101);
  endtask

  task automatic t_upgrade;
    issue(2'd0, 3, 1);
    expect_cmds("R3 upgrade", 4'b0101, 4'b0100, 2'b00, 1'b0);
    ack_all("R3 upgrade", 4'b0101, 2'b00);
    look("R3 requester modified", 1, 4'b1000, 4'b1000, 4'b0000);
  endtask

  task automatic t_writeback_dirty;
    issue(2'd1, 3, 1);
    expect_cmds("R4 dirty writeback", 4'h0, 4'h0, 2'b10, 1'b1);
    ack_all("R4 writeback", 4'h0, 2'b10);
    look("R4 all invalid", 1, 4'h0, 4'h0, 4'h0);
  endtask

  task automatic t_other_line;
    issue(2'd3, 1, 2);
    expect_cmds("R7 store fetch ch0", 4'h0, 4'h0, 2'b01, 1'b0);
    ack_all("R7 store fetch", 4'h0, 2'b01);
    look("R6 line2 modified", 2, 4'b0010, 4'b0010, 4'b0000);
    look("R11 line1 untouched", 1, 4'h0, 4'h0, 4'h0);
  endtask

  task automatic t_home_rereads;
    issue(2'd2, 1, 2);
    expect_cmds("R5 home rereads", 4'h0, 4'h0, 2'b00, 1'b0);
    ack_all("R5 no-op", 4'h0, 2'b00);
    look("R5 home unchanged", 2, 4'b0010, 4'b0010, 4'b0000);
  endtask

  task automatic t_store_steal;
    issue(2'd3, 0, 2);
    expect_cmds("R6 steal from home", 4'b0010, 4'b0010, 2'b00, 1'b0);
    ack_all("R6 steal", 4'b0010, 2'b00);
    look("R6 new owner", 2, 4'b0001, 4'b0001, 4'b0000);
  endtask

  task automatic t_clean_writeback;
    issue(2'd2, 2, 2);
    expect_cmds("R5 reader of modified", 4'h0, 4'b0001, 2'b00, 1'b0);
    ack_all("R5 reader", 4'b0001, 2'b00);
    look("R5 owned", 2, 4'b0101, 4'b0001, 4'b0101);
    issue(2'd1, 2, 2);
    expect_cmds("R4 clean writeback", 4'b0001, 4'b0001, 2'b00, 1'b0);
    ack_all("R4 clean", 4'b0001, 2'b00);
    look("R4 line cleared", 2, 4'h0, 4'h0, 4'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0;
    req_kind = '0;
    req_core = '0;
    req_line = '0;
    core_ack = '0;
    mem_ack = '0;
    look_line = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_first_load;
    t_second_load;
    t_store_delayed_acks;
    t_load_from_home;
    t_upgrade;
    t_writeback_dirty;
    t_other_line;
    t_home_rereads;
    t_store_steal;
    t_clean_writeback;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule